// File: doc/BRIEF.md
# UART Modem Flow-Control Unit

This block sits between a UART's character FIFOs and its modem handshake pins. On the transmit side it decides whether the transmitter may start another character. It samples the clear-to-send pin through a two-stage synchronizer. When clear-to-send gating is enabled and that pin reads HIGH, the permit drops. The permit is only re-evaluated at character boundaries, so a character already on the wire always finishes.

On the receive side it drives the request-to-send pin with hysteresis. Each nibble of a trigger byte, multiplied by four, gives a receive-FIFO fill level. The low nibble sets the level at which the far end is halted. The high nibble sets the level at which it may resume. When automatic request-to-send is disabled, the pin follows a host-owned modem-control bit.

The block also compares every received byte with a programmable special character. A match sets a sticky flag, which the host clears by reading its interrupt identification value. Matched bytes are not dropped: every received byte is forwarded to the FIFO one cycle later.

Top module: `uart_flow_ctl`

## Requirements
- R1: With `ctsFlowEn` = 0, `txPermit` is 1 after every character boundary whatever level `ctsPin` has.
- R2: With `ctsFlowEn` = 1, a boundary taken when the synchronized `ctsPin` is HIGH clears `txPermit`. A boundary taken when it is LOW sets `txPermit`. The pin is sampled through two flops.
- R3: `txPermit` changes only in the cycle after a cycle with `txBoundary` = 1. Between boundaries it holds, whatever `ctsPin` does.
- R4: With `rtsFlowEn` = 1, when `rxLevel` >= 4 × `trigCtl[3:0]`, `rtsPin` is 1 in the next cycle.
- R5: With `rtsFlowEn` = 1, when `rxLevel` is below the halt level and <= 4 × `trigCtl[7:4]`, `rtsPin` is 0 in the next cycle. Strictly between the two levels, `rtsPin` keeps its previous value.
- R6: With `rtsFlowEn` = 0, `rtsPin` equals `mcrRts` in the same cycle.
- R7: A byte with `rxByteValid` = 1, `specDetEn` = 1 and `rxByte` == `specChar` sets `specFlag` in the next cycle. A non-matching byte, or any byte while `specDetEn` = 0, does not set it.
- R8: `specFlag` stays set until a cycle with `iirRead` = 1 and clears in the following cycle. A match in the same cycle as `iirRead` keeps it set.
- R9: Every byte with `rxByteValid` = 1 appears on `fifoData` with `fifoPush` = 1 in the next cycle, whether or not it matched.
- R10: After reset, `txPermit` = 1, `specFlag` = 0, `fifoPush` = 0 and the internal request-to-send state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctsFlowEn | input | 1 | Enable clear-to-send transmit gating |
| rtsFlowEn | input | 1 | Enable automatic request-to-send |
| specDetEn | input | 1 | Enable special-character compare |
| trigCtl | input | 8 | [3:0] halt level/4, [7:4] resume level/4 |
| specChar | input | 8 | Special character value |
| rxLevel | input | 7 | Receive FIFO fill level, 0 to 64 |
| rxByteValid | input | 1 | Received-byte strobe |
| rxByte | input | 8 | Received byte |
| ctsPin | input | 1 | Clear-to-send pin, asynchronous, HIGH = stop |
| txBoundary | input | 1 | Transmitter is between characters this cycle |
| mcrRts | input | 1 | Host request-to-send bit |
| iirRead | input | 1 | Single-cycle clear pulse from the interrupt ID read |
| txPermit | output | 1 | Transmitter may start the next character |
| rtsPin | output | 1 | Request-to-send pin, HIGH = halt far end |
| specFlag | output | 1 | Sticky special-character status bit |
| fifoPush | output | 1 | Write strobe to receive FIFO |
| fifoData | output | 8 | Byte to receive FIFO |

## Verification
The request-to-send hysteresis is driven by a walk of fill levels that climbs, falls and re-climbs through both thresholds. The walk separates crossing a threshold from sitting between them. It also covers a trigger setting whose halt level lies below the resume level, which shows that halting wins the overlap. Clear-to-send is toggled with boundaries withheld and then granted, which separates boundary-timed gating from immediate gating. Received bytes alternate between matching and non-matching values, with detection on and off and a read colliding with a match, which separates set, hold and clear precedence of the flag.

// File: rtl/flow_pkg.sv
package flow_pkg;
  // strobes from control into datapath
  typedef struct packed {
    logic pushByte;
    logic setSpec;
    logic clrSpec;
  } dpStrobe_t;

  // compare results from datapath back to control
  typedef struct packed {
    logic atHalt;
    logic atResume;
    logic charMatch;
  } dpStatus_t;
endpackage

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LVL_W     = 7,
  parameter int NIB_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*NIB_W-1:0]   trigCtl,
  input  logic [DATA_W-1:0]    specChar,
  input  logic [LVL_W-1:0]     rxLevel,
  input  logic [DATA_W-1:0]    rxByte,
  input  dpStrobe_t            strobe,
  output dpStatus_t            status,
  output logic                 specFlag,
  output logic                 fifoPush,
  output logic [DATA_W-1:0]    fifoData
);
  logic [LVL_W-1:0] haltLvl;
  logic [LVL_W-1:0] resumeLvl;

  // nibble scaled to a FIFO level
  assign haltLvl   = LVL_W'(trigCtl[NIB_W-1:0]) << THR_SHIFT;
  assign resumeLvl = LVL_W'(trigCtl[2*NIB_W-1:NIB_W]) << THR_SHIFT;

  always_comb begin
    status.atHalt    = (rxLevel >= haltLvl);
    status.atResume  = (rxLevel <= resumeLvl);
    status.charMatch = (rxByte == specChar);
  end

  // sticky flag, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                specFlag <= 1'b0;
    else if (strobe.setSpec)  specFlag <= 1'b1;
    else if (strobe.clrSpec)  specFlag <= 1'b0;
  end

  // every received byte passes on to the FIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoPush <= 1'b0;
      fifoData <= '0;
    end else begin
      fifoPush <= strobe.pushByte;
      if (strobe.pushByte) fifoData <= rxByte;
    end
  end
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctsFlowEn,
  input  logic      rtsFlowEn,
  input  logic      specDetEn,
  input  logic      ctsPin,
  input  logic      txBoundary,
  input  logic      rxByteValid,
  input  logic      iirRead,
  input  logic      mcrRts,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      txPermit,
  output logic      rtsPin
);
  logic [SYNC_STAGES-1:0] ctsChain;
  logic                   ctsSync;
  logic                   rtsState;

  // clear-to-send synchronizer
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ctsChain[s] <= 1'b0;
        else if (s == 0) ctsChain[s] <= ctsPin;
        else ctsChain[s] <= ctsChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign ctsSync = ctsChain[SYNC_STAGES-1];

  // permit re-evaluated only between characters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           txPermit <= 1'b1;
    else if (txBoundary) txPermit <= !(ctsFlowEn && ctsSync);
  end

  // request-to-send hysteresis, halting has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rtsState <= 1'b0;
    else if (!rtsFlowEn)      rtsState <= 1'b0;
    else if (status.atHalt)   rtsState <= 1'b1;
    else if (status.atResume) rtsState <= 1'b0;
  end

  assign rtsPin = rtsFlowEn ? rtsState : mcrRts;

  always_comb begin
    strobe.pushByte = rxByteValid;
    strobe.setSpec  = rxByteValid && specDetEn && status.charMatch;
    strobe.clrSpec  = iirRead;
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import flow_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int DATA_W      = 8,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int THR_SHIFT  = $clog2(FIFO_DEPTH) - NIB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctsFlowEn,
  input  logic               rtsFlowEn,
  input  logic               specDetEn,
  input  logic [2*NIB_W-1:0] trigCtl,
  input  logic [DATA_W-1:0]  specChar,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic               rxByteValid,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               ctsPin,
  input  logic               txBoundary,
  input  logic               mcrRts,
  input  logic               iirRead,
  output logic               txPermit,
  output logic               rtsPin,
  output logic               specFlag,
  output logic               fifoPush,
  output logic [DATA_W-1:0]  fifoData
);
  dpStrobe_t strobe;
  dpStatus_t status;

  flow_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk, .rstN, .ctsFlowEn, .rtsFlowEn, .specDetEn, .ctsPin, .txBoundary,
    .rxByteValid, .iirRead, .mcrRts, .status, .strobe, .txPermit, .rtsPin
  );

  flow_dp #(.DATA_W(DATA_W), .LVL_W(LVL_W), .NIB_W(NIB_W), .THR_SHIFT(THR_SHIFT)) u_dp (
    .clk, .rstN, .trigCtl, .specChar, .rxLevel, .rxByte, .strobe, .status,
    .specFlag, .fifoPush, .fifoData
  );
endmodule

// File: rtl/flow_chk.sv
module flow_chk #(
  parameter int DATA_W    = 8,
  parameter int LVL_W     = 7,
  parameter int NIB_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctsFlowEn,
  input logic               rtsFlowEn,
  input logic               specDetEn,
  input logic [2*NIB_W-1:0] trigCtl,
  input logic [DATA_W-1:0]  specChar,
  input logic [LVL_W-1:0]   rxLevel,
  input logic               rxByteValid,
  input logic [DATA_W-1:0]  rxByte,
  input logic               txBoundary,
  input logic               iirRead,
  input logic               txPermit,
  input logic               rtsPin,
  input logic               specFlag,
  input logic               fifoPush,
  input logic [DATA_W-1:0]  fifoData
);
  logic [LVL_W-1:0] chkHalt, chkResume;
  assign chkHalt   = LVL_W'(trigCtl[NIB_W-1:0]) << THR_SHIFT;
  assign chkResume = LVL_W'(trigCtl[2*NIB_W-1:NIB_W]) << THR_SHIFT;

  p_cts_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txBoundary && !ctsFlowEn) |=> txPermit);

  p_permit_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !txBoundary |=> $stable(txPermit));

  p_rts_halt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rtsFlowEn && rxLevel >= chkHalt) |=> (!rtsFlowEn || rtsPin));

  p_rts_resume_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rtsFlowEn && rxLevel < chkHalt && rxLevel <= chkResume) |=> (!rtsFlowEn || !rtsPin));

  p_spec_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && specDetEn && rxByte == specChar) |=> specFlag);

  p_spec_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (specFlag && !iirRead) |=> specFlag);

  p_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxByteValid |=> (fifoPush && fifoData == $past(rxByte)));
endmodule

bind uart_flow_ctl flow_chk #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .NIB_W(NIB_W), .THR_SHIFT(THR_SHIFT)
) u_flow_chk (
  .clk(clk), .rstN(rstN), .ctsFlowEn(ctsFlowEn), .rtsFlowEn(rtsFlowEn),
  .specDetEn(specDetEn), .trigCtl(trigCtl), .specChar(specChar),
  .rxLevel(rxLevel), .rxByteValid(rxByteValid), .rxByte(rxByte),
  .txBoundary(txBoundary), .iirRead(iirRead), .txPermit(txPermit),
  .rtsPin(rtsPin), .specFlag(specFlag), .fifoPush(fifoPush), .fifoData(fifoData)
);

// File: tb/test_uart_flow_ctl.sv
`timescale 1ns/1ps
module test_uart_flow_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsFlowEn = 0, rtsFlowEn = 0, specDetEn = 0;
  logic [7:0] trigCtl = '0, specChar = '0, rxByte = '0;
  logic [6:0] rxLevel = '0;
  logic rxByteValid = 0, ctsPin = 0, txBoundary = 0, mcrRts = 0, iirRead = 0;
  logic txPermit, rtsPin, specFlag, fifoPush;
  logic [7:0] fifoData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_flow_ctl i_uart_flow_ctl (
    .clk, .rstN, .ctsFlowEn, .rtsFlowEn, .specDetEn, .trigCtl, .specChar,
    .rxLevel, .rxByteValid, .rxByte, .ctsPin, .txBoundary, .mcrRts, .iirRead,
    .txPermit, .rtsPin, .specFlag, .fifoPush, .fifoData
  );

  // {trigCtl, rxLevel, expected rtsPin}
  localparam int NV = 13;
  localparam logic [15:0] RTS_VEC [NV] = '{
    {8'h4A, 7'd0,  1'b0}, {8'h4A, 7'd20, 1'b0}, {8'h4A, 7'd39, 1'b0},
    {8'h4A, 7'd40, 1'b1}, {8'h4A, 7'd50, 1'b1}, {8'h4A, 7'd30, 1'b1},
    {8'h4A, 7'd17, 1'b1}, {8'h4A, 7'd16, 1'b0}, {8'h4A, 7'd25, 1'b0},
    {8'h4A, 7'd64, 1'b1}, {8'h21, 7'd6,  1'b1}, {8'h21, 7'd2,  1'b0},
    {8'h21, 7'd4,  1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic boundary();
    txBoundary = 1'b1;
    step();
    txBoundary = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic rd);
    rxByte = b; rxByteValid = 1'b1; iirRead = rd;
    step();
    rxByteValid = 1'b0; iirRead = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    // R10 reset state
    chk("R10 txPermit", txPermit, 1);
    chk("R10 specFlag", specFlag, 0);
    chk("R10 fifoPush", fifoPush, 0);
    chk("R10 rtsPin", rtsPin, 0);
    rstN = 1'b1;
    step();

    // R6 host bit when automatic mode off
    mcrRts = 1'b1; #1;
    chk("R6 rtsPin follows mcrRts=1", rtsPin, 1);
    mcrRts = 1'b0; #1;
    chk("R6 rtsPin follows mcrRts=0", rtsPin, 0);

    // R4 / R5 hysteresis walk
    rtsFlowEn = 1'b1;
    for (int v = 0; v < NV; v++) begin
      trigCtl = RTS_VEC[v][15:8];
      rxLevel = RTS_VEC[v][7:1];
      step();
      chk($sformatf("R4/R5 vec %0d level %0d", v, RTS_VEC[v][7:1]), rtsPin, RTS_VEC[v][0]);
    end
    rtsFlowEn = 1'b0; mcrRts = 1'b0; #1;
    chk("R6 rtsPin after disable", rtsPin, 0);

    // R1 CTS ignored when gating off
    ctsPin = 1'b1; step(3);
    boundary();
    chk("R1 permit with CTS high, gating off", txPermit, 1);

    // R3 / R2 boundary-timed gating
    ctsFlowEn = 1'b1; step(4);
    chk("R3 permit held without boundary", txPermit, 1);
    boundary();
    chk("R2 permit cleared at boundary", txPermit, 0);
    ctsPin = 1'b0; step(4);
    chk("R3 permit held low without boundary", txPermit, 0);
    boundary();
    chk("R2 permit restored at boundary", txPermit, 1);
    ctsPin = 1'b1; step(1);
    boundary();
    chk("R2 sync delay: boundary before two flops", txPermit, 1);
    step(2);
    boundary();
    chk("R2 permit cleared after sync", txPermit, 0);
    ctsPin = 1'b0; ctsFlowEn = 1'b0;

    // R7 / R9 special character
    specDetEn = 1'b1; specChar = 8'h13;
    sendByte(8'h41, 1'b0);
    chk("R9 push on plain byte", fifoPush, 1);
    chk("R9 data of plain byte", fifoData, 8'h41);
    chk("R7 no flag on non-match", specFlag, 0);
    sendByte(8'h13, 1'b0);
    chk("R7 flag on match", specFlag, 1);
    chk("R9 matched byte still pushed", fifoData, 8'h13);
    step(3);
    chk("R8 flag holds", specFlag, 1);
    chk("R9 no push when idle", fifoPush, 0);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R8 flag cleared by read", specFlag, 0);
    specDetEn = 1'b0;
    sendByte(8'h13, 1'b0);
    chk("R7 no flag when detect off", specFlag, 0);
    chk("R9 push with detect off", fifoPush, 1);
    specDetEn = 1'b1;
    sendByte(8'h13, 1'b0);
    sendByte(8'h13, 1'b1);
    chk("R8 match beats simultaneous read", specFlag, 1);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R8 clear after collision", specFlag, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule